// File: doc/BRIEF.md
# Instruction Cache Range Invalidation Sequencer

This block turns a request to invalidate an address range of the instruction cache into a short series of register writes to an area-invalidate engine. A requester presents a start and an end address, or a single address in page mode, together with a one-cycle start pulse. The sequencer picks one power-of-two area size that depends only on the range length. It programs the engine's mask register once with that size and then issues area-invalidate commands that step through the range at that stride. Each command waits until the engine's busy flag has cleared.

The area size starts at the line size. It doubles once for every bit that is significant in the count of whole lines spanned, minus one. Because the first command is aligned down to the area size, an unaligned range can need two commands. The same stride is used for the whole range. When the cache is disabled, or when the range is empty, the request finishes at once and nothing is written. While a sweep is running, an interrupt-lock output is held high so that the requester's side cannot interleave other engine traffic. A one-cycle done pulse closes every accepted request.

Top module: `icache_sweep_seq`

## Requirements
- R1: When `cache_on` is low in the cycle a request is accepted, `done` is high in the very next cycle, and neither `mask_wr` nor `cmd_wr` is ever asserted for that request.
- R2: A range whose end is less than or equal to its start (compared as unsigned 32-bit values) also completes with one `done` pulse and no mask or command writes.
- R3: The area size begins at 16 bytes. It doubles once for each right shift needed to reduce ((end - start - 1) >> 4) to zero. The subtraction is taken without wrap.
- R4: Exactly one mask write occurs per non-empty enabled request, carrying NOT(area - 1) truncated to 32 bits. It does not occur while `eng_busy` stays high after the request is accepted.
- R5: The first command carries (start AND mask) with bit 0, the invalidate flag, set to 1.
- R6: After each command the sequencer waits for `eng_busy` to be low. It then adds the area size to the address and issues the next command while the sum is below the end address. The comparison uses 33 bits, so an address that reaches 2^32 stops the sweep instead of wrapping.
- R7: With `req_page` high, `req_hi` is ignored. The start becomes `req_lo` with its low 12 bits cleared, and the end becomes that start plus 4096.
- R8: `irq_lock` is high during every mask or command write, stays high from acceptance of a non-empty enabled request until its last command has completed, and is low otherwise.
- R9: Every accepted request produces exactly one single-cycle `done` pulse. A `req_valid` pulse that arrives while a sweep is running is ignored.
- R10: While `rst_n` is low, `done`, `irq_lock`, `mask_wr` and `cmd_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_page | input | 1 | Page-mode request: invalidate the 4 KiB page holding `req_lo` |
| req_lo | input | 32 | Range start address |
| req_hi | input | 32 | Range end address (exclusive) |
| cache_on | input | 1 | Instruction cache enable; low makes a request a no-op |
| eng_busy | input | 1 | Area-invalidate engine busy flag; must rise in the cycle after a command write |
| mask_wr | output | 1 | Mask register write strobe |
| mask_val | output | 32 | Mask value written with `mask_wr` |
| cmd_wr | output | 1 | Command register write strobe |
| cmd_val | output | 32 | Area address with the invalidate flag in bit 0 |
| irq_lock | output | 1 | Interrupt lock held for the duration of a sweep |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 16-byte lines, 4 KiB pages and the invalidate flag in bit 0. These values bring the top of the address space within reach, so ranges whose last area ends exactly at 2^32 can be tested, including a page-mode request on the final page. They also make spans of one, two, three and sixteen lines easy to write, which covers single-area sweeps, the unaligned two-command case and the full-page area. The engine model varies its busy time from request to request. The bench can also hold busy high from outside, to show that the mask write waits.

// File: rtl/icrs_pkg.sv
package icrs_pkg;

   // Sweep sequencer states; the order of states is the order of a sweep.
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DRAIN = 3'd1,
      ST_MASK  = 3'd2,
      ST_ISSUE = 3'd3,
      ST_WAIT  = 3'd4,
      ST_DONE  = 3'd5
   } sweep_state_t;

   // Width needed to hold a bit count of a vector that is n bits wide.
   function automatic int unsigned count_w(input int unsigned n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/icrs_req_front.sv
// Request front end: forms the sweep base and limit from the request.
// The limit is one bit wider than an address so a range can end at 2^AW.
module icrs_req_front #(
   parameter int unsigned AW        = 32,
   parameter int unsigned PAGE_LOG2 = 12,
   parameter bit          PAGE_EN   = 1'b1
) (
   input  logic          req_page,
   input  logic [AW-1:0] req_lo,
   input  logic [AW-1:0] req_hi,
   output logic [AW-1:0] base,
   output logic [AW:0]   limit,
   output logic          empty
);

   localparam logic [AW-1:0] PAGE_LOW  = (AW'(1) << PAGE_LOG2) - AW'(1);
   localparam logic [AW:0]   PAGE_SPAN = (AW+1)'(1) << PAGE_LOG2;

   generate
      if (PAGE_LOG2 >= AW) begin : g_bad_page
         $error("icrs_req_front: PAGE_LOG2 must be below AW");
      end

      if (PAGE_EN) begin : g_page
         logic [AW-1:0] page_base;
         assign page_base = req_lo & ~PAGE_LOW;
         always_comb begin
            if (req_page) begin
               base  = page_base;
               limit = {1'b0, page_base} + PAGE_SPAN;
            end else begin
               base  = req_lo;
               limit = {1'b0, req_hi};
            end
         end
      end else begin : g_range_only
         logic page_unused;
         assign page_unused = req_page;
         always_comb begin
            base  = req_lo;
            limit = {page_unused & 1'b0, req_hi};
         end
      end
   endgenerate

   // An end at or below the start leaves nothing to invalidate.
   assign empty = (limit <= {1'b0, base});

endmodule

// File: rtl/icrs_span_calc.sv
// Area size and mask from the latched range. The area is one line,
// doubled once for every significant bit of the spanned line count minus one.
module icrs_span_calc #(
   parameter int unsigned AW        = 32,
   parameter int unsigned LINE_LOG2 = 4
) (
   input  logic [AW-1:0] base,
   input  logic [AW:0]   limit,
   output logic [AW:0]   area,
   output logic [AW-1:0] mask
);

   localparam int unsigned BLW = icrs_pkg::count_w(AW + 1);

   logic [AW:0]    span_m1;
   logic [AW:0]    lines;
   logic [BLW-1:0] bitlen;

   generate
      if (LINE_LOG2 < 1 || LINE_LOG2 >= AW) begin : g_bad_line
         $error("icrs_span_calc: LINE_LOG2 out of range");
      end
   endgenerate

   assign span_m1 = limit - {1'b0, base} - (AW+1)'(1);
   assign lines   = span_m1 >> LINE_LOG2;

   // Position of the highest set bit plus one; zero for a zero count.
   always_comb begin
      bitlen = '0;
      for (int i = 0; i < AW + 1; i++) begin
         if (lines[i]) bitlen = BLW'(i + 1);
      end
   end

   always_comb begin
      area = (AW+1)'(1) << (LINE_LOG2 + int'(bitlen));
      mask = ~(area[AW-1:0] - AW'(1));
   end

endmodule

// File: rtl/icrs_seq_ctrl.sv
// Sweep sequencer: busy drain, single mask write, stepped command issue.
module icrs_seq_ctrl
   import icrs_pkg::*;
#(
   parameter int unsigned AW      = 32,
   parameter int unsigned INV_BIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          cache_on,
   input  logic          empty,
   input  logic [AW-1:0] base_in,
   input  logic [AW:0]   limit_in,
   input  logic [AW:0]   area,
   input  logic [AW-1:0] mask,
   input  logic          eng_busy,
   output logic [AW-1:0] base_q,
   output logic [AW:0]   limit_q,
   output logic          mask_wr,
   output logic [AW-1:0] mask_val,
   output logic          cmd_wr,
   output logic [AW-1:0] cmd_val,
   output logic          irq_lock,
   output logic          done
);

   localparam logic [AW-1:0] INV_FLAG = AW'(1) << INV_BIT;

   sweep_state_t  st;
   logic [AW-1:0] addr_q;
   logic [AW:0]   step;
   logic          more;

   generate
      if (INV_BIT >= AW) begin : g_bad_flag
         $error("icrs_seq_ctrl: INV_BIT outside the address word");
      end
   endgenerate

   assign step = {1'b0, addr_q} + area;
   assign more = (step < limit_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         base_q  <= '0;
         limit_q <= '0;
         addr_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  base_q  <= base_in;
                  limit_q <= limit_in;
                  st      <= (!cache_on || empty) ? ST_DONE : ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (!eng_busy) st <= ST_MASK;
            end
            ST_MASK: begin
               addr_q <= base_q & mask;
               st     <= ST_ISSUE;
            end
            ST_ISSUE: begin
               st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (!eng_busy) begin
                  if (more) begin
                     addr_q <= step[AW-1:0];
                     st     <= ST_ISSUE;
                  end else begin
                     st <= ST_DONE;
                  end
               end
            end
            ST_DONE: begin
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mask_wr  = (st == ST_MASK);
      mask_val = mask;
      cmd_wr   = (st == ST_ISSUE);
      cmd_val  = addr_q | INV_FLAG;
      irq_lock = (st == ST_DRAIN) || (st == ST_MASK) ||
                 (st == ST_ISSUE) || (st == ST_WAIT);
      done     = (st == ST_DONE);
   end

   // R1: a disabled cache turns the request straight into completion.
   a_r1_skip_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && req_valid && !cache_on) |=> (done && !irq_lock));

   // R4: the mask is written only after busy was seen low.
   a_r4_mask_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |-> $past(!eng_busy));

   // R6: no command leaves while the engine still reports busy.
   a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && eng_busy) |=> !cmd_wr);

   // R6: every command address lies below the end of the range.
   a_r6_cmd_below_end: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> ({1'b0, addr_q} < limit_q));

   // R3: each command address sits on an area boundary.
   a_r3_cmd_on_area: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> ((addr_q & (area[AW-1:0] - AW'(1))) == '0));

   // R8: every engine write happens under the lock.
   a_r8_lock_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr || mask_wr) |-> irq_lock);

   // R9: completion is a single-cycle pulse.
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/icache_sweep_seq.sv
// Instruction cache range invalidation sequencer, top level.
module icache_sweep_seq #(
   parameter int unsigned AW        = 32,
   parameter int unsigned LINE_LOG2 = 4,
   parameter int unsigned PAGE_LOG2 = 12,
   parameter bit          PAGE_EN   = 1'b1,
   parameter int unsigned INV_BIT   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_page,
   input  logic [AW-1:0] req_lo,
   input  logic [AW-1:0] req_hi,
   input  logic          cache_on,
   input  logic          eng_busy,
   output logic          mask_wr,
   output logic [AW-1:0] mask_val,
   output logic          cmd_wr,
   output logic [AW-1:0] cmd_val,
   output logic          irq_lock,
   output logic          done
);

   generate
      if (INV_BIT >= LINE_LOG2) begin : g_bad_flag
         $error("icache_sweep_seq: invalidate flag must sit inside the line offset");
      end
      if (PAGE_LOG2 < LINE_LOG2) begin : g_bad_page
         $error("icache_sweep_seq: a page must hold at least one line");
      end
   endgenerate

   logic [AW-1:0] fr_base;
   logic [AW:0]   fr_limit;
   logic          fr_empty;
   logic [AW-1:0] lat_base;
   logic [AW:0]   lat_limit;
   logic [AW:0]   sp_area;
   logic [AW-1:0] sp_mask;

   icrs_req_front #(
      .AW        (AW),
      .PAGE_LOG2 (PAGE_LOG2),
      .PAGE_EN   (PAGE_EN)
   ) u_front (
      .req_page (req_page),
      .req_lo   (req_lo),
      .req_hi   (req_hi),
      .base     (fr_base),
      .limit    (fr_limit),
      .empty    (fr_empty)
   );

   icrs_span_calc #(
      .AW        (AW),
      .LINE_LOG2 (LINE_LOG2)
   ) u_span (
      .base  (lat_base),
      .limit (lat_limit),
      .area  (sp_area),
      .mask  (sp_mask)
   );

   icrs_seq_ctrl #(
      .AW      (AW),
      .INV_BIT (INV_BIT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .cache_on  (cache_on),
      .empty     (fr_empty),
      .base_in   (fr_base),
      .limit_in  (fr_limit),
      .area      (sp_area),
      .mask      (sp_mask),
      .eng_busy  (eng_busy),
      .base_q    (lat_base),
      .limit_q   (lat_limit),
      .mask_wr   (mask_wr),
      .mask_val  (mask_val),
      .cmd_wr    (cmd_wr),
      .cmd_val   (cmd_val),
      .irq_lock  (irq_lock),
      .done      (done)
   );

   // R2: an empty range never reaches the engine.
   a_r2_empty_skips: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_lock && req_valid && fr_empty && !done) |=> !irq_lock);

endmodule

// File: tb/sim_icache_sweep_seq.sv
`timescale 1ns/1ps
module sim_icache_sweep_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_page = 1'b0;
   logic [31:0] req_lo = '0;
   logic [31:0] req_hi = '0;
   logic        cache_on = 1'b1;
   logic        eng_busy;
   logic        mask_wr, cmd_wr, irq_lock, done;
   logic [31:0] mask_val, cmd_val;

   always #2 clk = ~clk;   // 250 MHz

   icache_sweep_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
      .req_lo(req_lo), .req_hi(req_hi), .cache_on(cache_on), .eng_busy(eng_busy),
      .mask_wr(mask_wr), .mask_val(mask_val), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
      .irq_lock(irq_lock), .done(done)
   );

   // Stimulus table: start, end, page mode, cache enable.
   localparam int NV = 11;
   localparam logic [31:0] TV_LO [NV] = '{
      32'h0000_1000, 32'h0000_1004, 32'h0000_2000, 32'h0000_2010,
      32'h1234_5678, 32'h0000_0000, 32'h0000_3008, 32'h0000_1000,
      32'h0000_5000, 32'hFFFF_FFF0, 32'hFFFF_F800 };
   localparam logic [31:0] TV_HI [NV] = '{
      32'h0000_1010, 32'h0000_1024, 32'h0000_2100, 32'h0000_2110,
      32'h0000_0000, 32'h0000_0030, 32'h0000_3009, 32'h0000_2000,
      32'h0000_5000, 32'hFFFF_FFFF, 32'h0000_0000 };
   localparam logic [NV-1:0] TV_PG = 11'b100_0001_0000;
   localparam logic [NV-1:0] TV_EN = 11'b111_0111_1111;
   // Expected command counts, worked out from the requirements.
   localparam int TV_NCMD [NV] = '{1, 2, 1, 2, 1, 1, 1, 0, 0, 1, 1};

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   // Engine model and write log.
   int          busy_len = 2;
   int          busy_cnt = 0;
   logic        ext_busy = 1'b0;
   int          n_cmd = 0, n_mask = 0, n_done = 0, lock_bad = 0;
   logic [31:0] cmd_log [0:15];
   logic [31:0] last_mask = '0;

   assign eng_busy = (busy_cnt != 0) || ext_busy;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if ((cmd_wr || mask_wr) && !irq_lock) lock_bad = lock_bad + 1;
      if (mask_wr) begin
         n_mask = n_mask + 1;
         last_mask = mask_val;
      end
      if (done) n_done = n_done + 1;
      if (cmd_wr) begin
         if (n_cmd < 16) cmd_log[n_cmd] = cmd_val;
         n_cmd = n_cmd + 1;
         busy_cnt = busy_len;
      end else if (busy_cnt > 0) begin
         busy_cnt = busy_cnt - 1;
      end
      if (cyc > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_log();
      n_cmd = 0; n_mask = 0; n_done = 0;
   endtask

   task automatic issue_req(input logic [31:0] lo, input logic [31:0] hi,
                            input logic pg, input logic en);
      @(negedge clk);
      clear_log();
      req_lo = lo; req_hi = hi; req_page = pg; cache_on = en;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!done && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      if (guard >= 5000) chk(1'b0, "R9 done timeout", guard, 0);
      repeat (3) @(negedge clk);
   endtask

   // Reference plan from the requirement text: doubling loop for the area.
   task automatic plan(input logic [31:0] lo, input logic [31:0] hi, input logic pg,
                       output logic [32:0] base, output logic [32:0] limit,
                       output logic [32:0] area);
      logic [32:0] c;
      if (pg) begin
         base  = {1'b0, lo & 32'hFFFF_F000};
         limit = base + 33'd4096;
      end else begin
         base  = {1'b0, lo};
         limit = {1'b0, hi};
      end
      area = 33'd16;
      if (limit > base) begin
         c = (limit - base - 33'd1) >> 4;
         while (c != 0) begin
            area = area << 1;
            c = c >> 1;
         end
      end
   endtask

   initial begin
      // R10: outputs quiet in reset
      repeat (3) @(negedge clk);
      chk({done, irq_lock, mask_wr, cmd_wr} == 4'b0, "R10 reset outputs",
          {done, irq_lock, mask_wr, cmd_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [32:0] b, l, a, x;
         logic [31:0] em;
         int          nexp, bad;
         busy_len = (i % 3) + 1;
         plan(TV_LO[i], TV_HI[i], TV_PG[i], b, l, a);
         em = ~(a[31:0] - 32'd1);
         nexp = (TV_EN[i] && l > b) ? TV_NCMD[i] : 0;
         issue_req(TV_LO[i], TV_HI[i], TV_PG[i], TV_EN[i]);
         wait_done();
         chk(n_cmd == nexp, TV_PG[i] ? "R7 page command count" :
             (!TV_EN[i] ? "R1 disabled count" : (l <= b ? "R2 empty count" : "R6 command count")),
             n_cmd, nexp);
         chk(n_mask == (nexp > 0 ? 1 : 0), "R4 mask write count", n_mask, (nexp > 0));
         if (nexp > 0) begin
            chk(last_mask == em, "R3 mask value", last_mask, em);
            chk(cmd_log[0] == (((b[31:0]) & em) | 32'd1), "R5 first command",
                cmd_log[0], ((b[31:0]) & em) | 32'd1);
            bad = 0;
            x = {1'b0, b[31:0] & em};
            for (int k = 0; k < nexp && k < 16; k++) begin
               if (cmd_log[k] != (x[31:0] | 32'd1)) bad++;
               x = x + a;
            end
            chk(bad == 0 && x >= l, "R6 stepped commands", bad, 0);
         end
         chk(n_done == 1, "R9 one done pulse", n_done, 1);
         chk(!irq_lock, "R8 lock released", irq_lock, 0);
      end

      // R1: disabled request completes in the next cycle
      issue_req(32'h0000_4000, 32'h0000_8000, 1'b0, 1'b0);
      chk(done == 1'b1, "R1 immediate done", done, 1);
      wait_done();

      // R4 / R8: mask write waits for busy to drop, lock already held
      busy_len = 2;
      ext_busy = 1'b1;
      issue_req(32'h0000_0100, 32'h0000_0140, 1'b0, 1'b1);
      repeat (8) @(negedge clk);
      chk(n_mask == 0 && n_cmd == 0, "R4 mask held off by busy", n_mask + n_cmd, 0);
      chk(irq_lock == 1'b1, "R8 lock during drain", irq_lock, 1);
      ext_busy = 1'b0;
      wait_done();
      chk(n_mask == 1 && last_mask == 32'hFFFF_FFC0, "R4 mask after drain", last_mask, 32'hFFFF_FFC0);
      chk(n_cmd == 1 && cmd_log[0] == 32'h0000_0101, "R5 drained command", cmd_log[0], 32'h101);

      // R9: a request during a sweep is ignored
      busy_len = 6;
      issue_req(32'h0000_8010, 32'h0000_8110, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      req_lo = 32'h0; req_hi = 32'h0001_0000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      chk(n_cmd == 2 && cmd_log[0] == 32'h0000_8001 && cmd_log[1] == 32'h0000_8101,
          "R9 mid-sweep request ignored", n_cmd, 2);
      chk(n_done == 1, "R9 single done after ignored request", n_done, 1);

      // R7: page mode ignores req_hi
      busy_len = 1;
      issue_req(32'h0000_0ABC, 32'h0000_0001, 1'b1, 1'b1);
      wait_done();
      chk(n_cmd == 1 && cmd_log[0] == 32'h0000_0001 && last_mask == 32'hFFFF_F000,
          "R7 page ignores end input", cmd_log[0], 32'h1);

      chk(lock_bad == 0, "R8 writes under lock", lock_bad, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule